// File: doc/BRIEF.md
# GPIO Port Register File with Masked Writes

This block is the register file for one eight-pin general-purpose I/O port. It sits on a simple 32-bit register bus (address, write enable, write data, combinational read data) and holds, per pin, a function-select bit that hands the pad to the GPIO logic, an output-enable bit and an output value. It also returns the pad inputs after a synchronizer, and keeps the interrupt status, enable and type registers that a companion edge/level detector consumes and feeds back into.

Four such ports share a bank, 4 bytes apart, and each register kind sits 16 bytes after the previous one. The parameter `PORT_IDX` picks which of the four word slots this instance answers. Every writable register has a second, masked address at its plain address plus `UPPER_OFS`. A write there changes only the pins whose mask bit is set, so driver code can flip one pin without a read-modify-write sequence. The usual way to turn a pin into an output is to write its value first, then its output enable, then its function select. Because of that order the pad never drives a stale value.

Top module: `gpio_port_regs`

## Requirements
- R1: While reset is low, every writable register clears to 0. After reset, `pad_oe`, `pad_out`, `pin_func`, `irq_enable`, `irq_type` and `irq_status` are all 0, and every register reads 0.
- R2: A plain write replaces the whole register from `bus_wdata[7:0]`, and a read returns that register in bits 7:0 with bits 31:8 zero. Plain addresses are register index × 0x10 + `PORT_IDX` × 4. The register indices are: 0 function select, 1 output enable, 2 output value, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type, 7 interrupt clear.
- R3: A write to a masked address (plain address + `UPPER_OFS`) of function select, output enable, output value, interrupt status, interrupt enable or interrupt type gives register bit n the value of `bus_wdata[n]` where `bus_wdata[8+n]` is 1, and leaves bit n unchanged where it is 0.
- R4: A read of a masked address returns the current register value in bits 7:0 and zero in bits 31:8.
- R5: The input register (index 3) returns `pad_in` delayed by the two flops of the synchronizer. A change of `pad_in` becomes readable after the second rising edge. Writes to its plain or masked address change nothing.
- R6: `pad_out` equals the output-value register. `pad_oe[n]` is 1 only when both function-select bit n and output-enable bit n are 1.
- R7: An `irq_event[n]` pulse sets status bit n at the next edge. A plain write to the clear register (index 7) clears every status bit whose write bit is 1. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R8: `pin_func`, `irq_status`, `irq_enable` and `irq_type` present the current register values. The status register can also be written directly, by plain or masked write.
- R9: An address whose port slot differs from `PORT_IDX`, that is not word aligned, or that falls outside both the plain and masked regions is ignored on write and reads 0.
- R10: The clear register always reads 0. Writes to the masked address of the clear register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; bits 15:8 are the mask on masked writes |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad drive enables |
| pin_func | output | 8 | Per-pin function select, 1 = GPIO owns the pad |
| irq_event | input | 8 | Per-pin detection pulses from the companion block |
| irq_status | output | 8 | Latched interrupt status |
| irq_enable | output | 8 | Interrupt enable register |
| irq_type | output | 8 | Interrupt type register |

## Verification
The assertions take for granted that `bus_we` is a single-cycle strobe with address and data stable around the edge, and that `irq_event` carries pulses that are synchronous to `clk`. The hold properties (no change without a write, no change on an all-zero mask, no change on an undecoded address) assume that nothing but the bus and the reset moves the pin registers. The stimulus drives every input on the falling edge and holds it for one full cycle. It keeps `pad_in` still while the input register is being read, so the two-edge synchronizer delay can be checked exactly.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NPINS       = 8;
    localparam int NREGS       = 8;
    localparam int REG_STRIDE  = 16;
    localparam int PORT_STRIDE = 4;
    localparam int REGION      = NREGS * REG_STRIDE;

    typedef logic [NPINS-1:0] pins_t;

    // Index order sets the address offsets (index * REG_STRIDE).
    typedef enum logic [2:0] {
        RG_FSEL = 3'd0,
        RG_OEN  = 3'd1,
        RG_OVAL = 3'd2,
        RG_IN   = 3'd3,
        RG_ISTA = 3'd4,
        RG_IEN  = 3'd5,
        RG_ITYP = 3'd6,
        RG_ICLR = 3'd7
    } reg_sel_e;

    typedef struct packed {
        pins_t fsel;
        pins_t oen;
        pins_t oval;
        pins_t ista;
        pins_t ien;
        pins_t ityp;
    } port_state_t;

    // Whole-register replace, or per-pin update under a mask.
    function automatic pins_t merge_pins(pins_t cur, pins_t val, pins_t mask, logic masked);
        return masked ? ((cur & ~mask) | (val & mask)) : val;
    endfunction

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PORT_IDX  = 0,
    parameter int UPPER_OFS = 'h80
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              masked,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] PLAIN_END  = ADDR_W'(REGION);
    localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(UPPER_OFS);
    localparam logic [ADDR_W-1:0] ALIAS_END  = ADDR_W'(UPPER_OFS + REGION);
    localparam logic [1:0]        SLOT       = 2'(PORT_IDX);

    logic [ADDR_W-1:0] off;
    logic              in_region;

    always_comb begin
        off       = '0;
        in_region = 1'b0;
        masked    = 1'b0;
        if (addr < PLAIN_END) begin
            off       = addr;
            in_region = 1'b1;
        end else if (addr >= ALIAS_BASE && addr < ALIAS_END) begin
            off       = addr - ALIAS_BASE;
            in_region = 1'b1;
            masked    = 1'b1;
        end
        hit = in_region && (off[3:2] == SLOT) && (off[1:0] == 2'b00)
              && (off[ADDR_W-1:7] == '0);
        sel = reg_sel_e'(off[6:4]);
    end

endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
    import gpio_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t din,
    output pins_t dout
);
    pins_t stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_readmux.sv
module gpio_port_readmux
    import gpio_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  port_state_t       st,
    input  pins_t             sync_in,
    input  logic              hit,
    input  reg_sel_e          sel,
    output logic [DATA_W-1:0] rdata
);
    pins_t val;

    always_comb begin
        unique case (sel)
            RG_FSEL: val = st.fsel;
            RG_OEN:  val = st.oen;
            RG_OVAL: val = st.oval;
            RG_IN:   val = sync_in;
            RG_ISTA: val = st.ista;
            RG_IEN:  val = st.ien;
            RG_ITYP: val = st.ityp;
            default: val = '0;
        endcase
        rdata = '0;
        if (hit) rdata[NPINS-1:0] = val;
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int PORT_IDX    = 0,
    parameter int UPPER_OFS   = 'h80,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe,
    output logic [7:0]        pin_func,
    input  logic [7:0]        irq_event,
    output logic [7:0]        irq_status,
    output logic [7:0]        irq_enable,
    output logic [7:0]        irq_type
);
    port_state_t st_d, st_q;
    logic        hit, masked;
    reg_sel_e    sel;
    pins_t       sync_in;
    pins_t       wval, wmask;
    logic        wr;

    wire unused_wdata_hi = ^bus_wdata[DATA_W-1:2*NPINS];

    gpio_port_decode #(
        .ADDR_W(ADDR_W), .PORT_IDX(PORT_IDX), .UPPER_OFS(UPPER_OFS)
    ) u_decode (
        .addr(bus_addr), .hit(hit), .masked(masked), .sel(sel)
    );

    gpio_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_in)
    );

    gpio_port_readmux #(.DATA_W(DATA_W)) u_read (
        .st(st_q), .sync_in(sync_in), .hit(hit), .sel(sel), .rdata(bus_rdata)
    );

    always_comb begin
        st_d  = st_q;
        wval  = bus_wdata[NPINS-1:0];
        wmask = bus_wdata[2*NPINS-1:NPINS];
        wr    = bus_we && hit;
        if (wr) begin
            unique case (sel)
                RG_FSEL: st_d.fsel = merge_pins(st_q.fsel, wval, wmask, masked);
                RG_OEN:  st_d.oen  = merge_pins(st_q.oen,  wval, wmask, masked);
                RG_OVAL: st_d.oval = merge_pins(st_q.oval, wval, wmask, masked);
                RG_ISTA: st_d.ista = merge_pins(st_q.ista, wval, wmask, masked);
                RG_IEN:  st_d.ien  = merge_pins(st_q.ien,  wval, wmask, masked);
                RG_ITYP: st_d.ityp = merge_pins(st_q.ityp, wval, wmask, masked);
                RG_ICLR: if (!masked) st_d.ista = st_q.ista & ~wval;
                default: ;
            endcase
        end
        // detections win over a clear in the same cycle
        st_d.ista = st_d.ista | irq_event;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pad_out    = st_q.oval;
    assign pad_oe     = st_q.fsel & st_q.oen;
    assign pin_func   = st_q.fsel;
    assign irq_status = st_q.ista;
    assign irq_enable = st_q.ien;
    assign irq_type   = st_q.ityp;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int UPPER_OFS = 'h80
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [7:0]        pad_out,
    input logic [7:0]        pad_oe,
    input logic [7:0]        pin_func,
    input logic [7:0]        irq_event,
    input logic [7:0]        irq_status,
    input logic [7:0]        irq_enable,
    input logic [7:0]        irq_type
);
    localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'(UPPER_OFS);
    localparam logic [ADDR_W-1:0] ALIAS_END  = ADDR_W'(UPPER_OFS + gpio_port_pkg::REGION);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == 8'h00 && pad_out == 8'h00 && pin_func == 8'h00
                    && irq_enable == 8'h00 && irq_type == 8'h00));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pin_func)
                     && $stable(irq_enable) && $stable(irq_type)));

    assert_empty_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= ALIAS_BASE && bus_wdata[15:8] == 8'h00)
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pin_func)
             && $stable(irq_enable) && $stable(irq_type)));

    assert_drive_needs_func_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~pin_func) == 8'h00);

    assert_event_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_event != 8'h00) |=> ((irq_status & $past(irq_event)) == $past(irq_event)));

    assert_outside_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= ALIAS_END)
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pin_func)
             && $stable(irq_enable) && $stable(irq_type)));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPPER_OFS(UPPER_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .pin_func(pin_func), .irq_event(irq_event), .irq_status(irq_status),
    .irq_enable(irq_enable), .irq_type(irq_type)
);

// File: tb/gpio_port_regs_test.sv
module gpio_port_regs_test;
    import gpio_port_pkg::*;

    localparam int AW   = 12;
    localparam int PIDX = 2;
    localparam int UOFS = 'h80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [7:0]    pad_in = '0, pad_out, pad_oe, pin_func;
    logic [7:0]    irq_event = '0, irq_status, irq_enable, irq_type;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model
    pins_t m_fsel = '0, m_oen = '0, m_oval = '0, m_ista = '0, m_ien = '0, m_ityp = '0;
    pins_t m_pad = '0;

    gpio_port_regs #(.ADDR_W(AW), .PORT_IDX(PIDX), .UPPER_OFS(UOFS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_func(pin_func),
        .irq_event(irq_event), .irq_status(irq_status),
        .irq_enable(irq_enable), .irq_type(irq_type)
    );

    always #5 clk = ~clk;

    function automatic logic [AW-1:0] addr_of(int idx, bit msk);
        return AW'((msk ? UOFS : 0) + idx * 16 + PIDX * 4);
    endfunction

    function automatic pins_t mrg(pins_t cur, logic [31:0] d, bit msk);
        return msk ? ((cur & ~d[15:8]) | (d[7:0] & d[15:8])) : d[7:0];
    endfunction

    function automatic logic [31:0] exp_read(int idx);
        case (idx)
            0: return {24'h0, m_fsel};
            1: return {24'h0, m_oen};
            2: return {24'h0, m_oval};
            3: return {24'h0, m_pad};
            4: return {24'h0, m_ista};
            5: return {24'h0, m_ien};
            6: return {24'h0, m_ityp};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one bus write plus event vector; model updated for a decoded register
    task automatic wr(int idx, bit msk, logic [31:0] d, pins_t ev);
        @(negedge clk);
        bus_addr = addr_of(idx, msk); bus_we = 1'b1; bus_wdata = d; irq_event = ev;
        @(posedge clk);
        case (idx)
            0: m_fsel = mrg(m_fsel, d, msk);
            1: m_oen  = mrg(m_oen,  d, msk);
            2: m_oval = mrg(m_oval, d, msk);
            4: m_ista = mrg(m_ista, d, msk);
            5: m_ien  = mrg(m_ien,  d, msk);
            6: m_ityp = mrg(m_ityp, d, msk);
            7: if (!msk) m_ista = m_ista & ~d[7:0];
            default: ;
        endcase
        m_ista = m_ista | ev;
        @(negedge clk);
        bus_we = 1'b0; irq_event = '0;
    endtask

    task automatic raw_wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(string req, logic [AW-1:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic outs(string req);
        chk({req, " pad_out"},    {24'h0, pad_out},    {24'h0, m_oval});
        chk({req, " pad_oe"},     {24'h0, pad_oe},     {24'h0, m_fsel & m_oen});
        chk({req, " pin_func"},   {24'h0, pin_func},   {24'h0, m_fsel});
        chk({req, " irq_status"}, {24'h0, irq_status}, {24'h0, m_ista});
        chk({req, " irq_enable"}, {24'h0, irq_enable}, {24'h0, m_ien});
        chk({req, " irq_type"},   {24'h0, irq_type},   {24'h0, m_ityp});
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        outs("R1");
        for (int i = 0; i < 8; i++) rd("R1 read", addr_of(i, 0), 32'h0);
        rst_n = 1'b1;

        // R2: plain writes, upper write bits do not show in reads
        wr(0, 0, 32'hFFFF_FFA5, '0);
        wr(1, 0, 32'h1234_5633, '0);
        wr(5, 0, 32'h0000_00C3, '0);
        wr(6, 0, 32'h0000_0F0F, '0);
        rd("R2 fsel", addr_of(0, 0), 32'h0000_00A5);
        rd("R2 oen",  addr_of(1, 0), 32'h0000_0033);
        rd("R2 ien",  addr_of(5, 0), 32'h0000_00C3);
        rd("R2 ityp", addr_of(6, 0), 32'h0000_000F);
        outs("R2");

        // R3: masked update of low nibble; R4: alias read
        wr(2, 0, 32'h0000_00F0, '0);
        wr(2, 1, 32'h0000_0F03, '0);
        rd("R3 oval", addr_of(2, 0), 32'h0000_00F3);
        rd("R4 alias", addr_of(2, 1), 32'h0000_00F3);
        wr(0, 1, 32'hFFFF_00FF, '0);
        rd("R3 empty mask", addr_of(0, 0), {24'h0, m_fsel});

        // R6: output bring-up order on pin 6
        wr(0, 0, 32'h0, '0); wr(1, 0, 32'h0, '0);
        wr(2, 1, 32'h0000_4040, '0);
        chk("R6 value only", {24'h0, pad_oe}, 32'h0);
        wr(1, 1, 32'h0000_4040, '0);
        chk("R6 oe without func", {24'h0, pad_oe}, 32'h0);
        wr(0, 1, 32'h0000_4040, '0);
        chk("R6 driven", {24'h0, pad_oe}, 32'h40);
        outs("R6");

        // R5: two-edge synchronizer, writes ignored
        @(negedge clk); pad_in = 8'h5A; bus_addr = addr_of(3, 0);
        @(negedge clk); #1 chk("R5 one edge", bus_rdata, {24'h0, m_pad});
        @(negedge clk); m_pad = 8'h5A; #1 chk("R5 two edges", bus_rdata, 32'h5A);
        wr(3, 0, 32'h0000_00FF, '0);
        wr(3, 1, 32'h0000_FFFF, '0);
        rd("R5 write ignored", addr_of(3, 0), 32'h5A);
        rd("R5 alias read", addr_of(3, 1), 32'h5A);
        outs("R5");

        // R7: events, clear, collision
        wr(5, 1, 32'h0, 8'h81);
        rd("R7 set", addr_of(4, 0), {24'h0, m_ista});
        chk("R7 status out", {24'h0, irq_status}, 32'h81);
        wr(7, 0, 32'h0000_0001, '0);
        chk("R7 clear", {24'h0, irq_status}, 32'h80);
        wr(7, 0, 32'h0000_0080, 8'h80);
        chk("R7 event wins", {24'h0, irq_status}, 32'h80);
        // R10: clear reads 0, masked clear ignored
        rd("R10 clear reads 0", addr_of(7, 0), 32'h0);
        wr(7, 1, 32'h0000_FFFF, '0);
        chk("R10 alias clear ignored", {24'h0, irq_status}, 32'h80);
        // R8: direct status writes
        wr(4, 0, 32'h0000_0011, '0);
        wr(4, 1, 32'h0000_0101, '0);
        chk("R8 status write", {24'h0, irq_status}, 32'h11);
        outs("R8");

        // R9: undecoded addresses
        raw_wr(AW'(PIDX * 4 - 4), 32'h0000_00FF);
        raw_wr(AW'(UOFS + 128 + PIDX * 4), 32'h0000_FFFF);
        raw_wr(AW'(PIDX * 4 + 1), 32'h0000_00FF);
        raw_wr(AW'(UOFS + 16 + PIDX * 4 + 4), 32'h0000_FFFF);
        outs("R9");
        rd("R9 other slot", AW'(PIDX * 4 - 4), 32'h0);
        rd("R9 beyond", AW'(UOFS + 128 + PIDX * 4), 32'h0);
        rd("R9 misaligned", AW'(PIDX * 4 + 1), 32'h0);

        // random mix, R2 R3 R4 R6 R7 R8
        for (int n = 0; n < 400; n++) begin
            int    idx = int'($urandom_range(0, 7));
            bit    msk = 1'($urandom_range(0, 1));
            pins_t ev  = ($urandom_range(0, 3) == 0) ? pins_t'($urandom) : '0;
            wr(idx, msk, $urandom, ev);
            outs("R8 random");
            begin
                int ri = int'($urandom_range(0, 7));
                bit rm = 1'($urandom_range(0, 1));
                rd(rm ? "R4 random" : "R2 random", addr_of(ri, rm), exp_read(ri));
            end
        end

        finish_run();
    end

endmodule